// File: doc/BRIEF.md
# Delay-Tap Tuning Sweep Controller

This block calibrates the sampling delay of a high-speed memory-card receive path. When started in the one accepted bus mode, it walks a delay tap upward from zero over a fixed safe range. For each tap it programs the delay line through a request/acknowledge pair. Once the tap is in place it asks an external agent to run a tuning-block transfer, and it records whether that transfer passed. A tap whose programming is never acknowledged counts as failing, and so does a failed transfer.

During the sweep the block tracks the current run of consecutive passing taps and the best run found so far. At the end it programs the tap at the centre of the longest passing window through the same handshake. It then pulses done. When no tap passed, or the bus mode is wrong, it raises an error flag instead and programs nothing further. The transfer engine, the command encoding and the delay line all sit outside the block.

Top module: `tap_sweep_tuner`

## Requirements
- R1: After an accepted start, tap values are offered in strictly ascending order from 0 to NUM_TAPS-1 (default 39). While the apply request is high, the tap output never exceeds NUM_TAPS-1.
- R2: An apply request (`tapApplyReq` high) holds `tapVal` constant until `tapApplyAck` is seen. The transfer request for a tap is raised only after that tap's acknowledge.
- R3: If no acknowledge arrives within ACK_TIMEOUT cycles (default 16), the request is dropped and the tap counts as failing. No transfer is requested for that tap.
- R4: `xferReq` stays high until `xferDone`. The tap passes when `xferPass` is 1 in the `xferDone` cycle and fails otherwise. A failing tap resets the current run to zero.
- R5: The final tap equals E - (L div 2). Here L is the length of the longest run of passing taps and E is the last tap of that run. A later run of equal length does not replace an earlier one.
- R6: The final tap is programmed with the same apply handshake, and done follows its acknowledge. If that acknowledge times out, the error flag is set.
- R7: If no tap passed, the error flag is set and no final tap is applied.
- R8: Tuning starts only when `modeSel` equals HS200_CODE (default 5). Any other mode sets the error flag and pulses done, with no apply and no transfer.
- R9: `done` is high for exactly one cycle per start. `error` stays set until the next accepted start pulse clears it.
- R10: Out of reset, `done`, `error`, `tapApplyReq` and `xferReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a tuning sweep (sampled when idle) |
| modeSel | input | MODE_W | Current bus timing mode code |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Tuning failed or mode rejected; held until next start |
| tapVal | output | TAP_W | Delay tap value presented to the delay line |
| tapApplyReq | output | 1 | Request to load `tapVal` into the delay line |
| tapApplyAck | input | 1 | Delay line has taken the tap |
| xferReq | output | 1 | Request a tuning-block transfer at the current tap |
| xferDone | input | 1 | Transfer finished this cycle |
| xferPass | input | 1 | Transfer result, valid with `xferDone` |

## Verification
The assertions assume a well-behaved environment. `tapApplyAck` is raised only while a request is pending and drops once the request drops. `xferDone` comes only while `xferReq` is high. `start` is not pulsed during a sweep. The bench responders are level-based and gate acknowledge and completion on the matching request, so the stimulus stays inside these assumptions. Pass masks and withheld-acknowledge masks are swept per tap to reach the window-selection corner cases.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_XFER,
    ST_NEXT,
    ST_EVAL,
    ST_FINAL,
    ST_FIN
  } tuneState_t;

  typedef struct packed {
    logic clearAll;
    logic recPass;
    logic recFail;
    logic incTap;
    logic loadFinal;
    logic toRun;
  } dpStrobe_t;

endpackage

// File: rtl/tuner_dpath.sv
module tuner_dpath
  import tuner_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  output logic [TAP_W-1:0] tapVal,
  output logic             lastTap,
  output logic             anyPass,
  output logic             timeout
);

  localparam int CNT_W = $clog2(NUM_TAPS + 1);
  localparam int TO_W  = $clog2(ACK_TIMEOUT + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(NUM_TAPS);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(ACK_TIMEOUT - 1);

  logic [TAP_W-1:0] tapReg, bestEnd, finalTap;
  logic [CNT_W-1:0] curRun, bestLen, runNext;
  logic [TO_W-1:0]  toCnt;

  assign runNext  = curRun + 1'b1;
  assign finalTap = bestEnd - TAP_W'(bestLen >> 1);

  // Sweep tap, current run and best window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapReg  <= '0;
      curRun  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (stb.clearAll) begin
      tapReg  <= '0;
      curRun  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else begin
      if (stb.recPass) begin
        curRun <= runNext;
        if (runNext > bestLen) begin  // strict: earliest longest window is kept
          bestLen <= runNext;
          bestEnd <= tapReg;
        end
      end else if (stb.recFail) begin
        curRun <= '0;
      end
      if (stb.incTap)
        tapReg <= tapReg + 1'b1;
      else if (stb.loadFinal)
        tapReg <= finalTap;
    end
  end

  // Acknowledge wait counter
  always_ff @(posedge clk) begin
    if (!rstN)          toCnt <= '0;
    else if (!stb.toRun) toCnt <= '0;
    else if (toCnt != TO_LAST) toCnt <= toCnt + 1'b1;
  end

  assign tapVal  = tapReg;
  assign lastTap = (tapReg == LAST_TAP);
  assign anyPass = (bestLen != '0);
  assign timeout = stb.toRun && (toCnt == TO_LAST);

  // R5: best length only grows within a sweep
  p_best_grows_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clearAll |=> bestLen >= $past(bestLen));

  // R5: the programmed final tap lies inside the best window
  p_final_in_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadFinal |=> (tapVal <= $past(bestEnd)) && ($past(bestEnd) - tapVal < TAP_W'($past(bestLen))));

  // R4: the run length never exceeds the sweep size
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.recPass |=> curRun <= RUN_MAX);

endmodule

// File: rtl/tuner_ctrl.sv
module tuner_ctrl
  import tuner_pkg::*;
#(
  parameter int             MODE_W     = 3,
  parameter logic [MODE_W-1:0] HS200_CODE = MODE_W'(5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              tapApplyAck,
  input  logic              xferDone,
  input  logic              xferPass,
  input  logic              lastTap,
  input  logic              anyPass,
  input  logic              timeout,
  output dpStrobe_t         stb,
  output logic              tapApplyReq,
  output logic              xferReq,
  output logic              done,
  output logic              error
);

  tuneState_t state, stateNxt;
  logic errSet, errClr;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    errSet   = 1'b0;
    errClr   = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        errClr = 1'b1;
        if (modeSel != HS200_CODE) begin
          errSet   = 1'b1;
          stateNxt = ST_FIN;
        end else begin
          stb.clearAll = 1'b1;
          stateNxt     = ST_APPLY;
        end
      end
      ST_APPLY: begin
        stb.toRun = 1'b1;
        if (tapApplyAck) begin
          stateNxt = ST_XFER;
        end else if (timeout) begin
          stb.recFail = 1'b1;
          stateNxt    = ST_NEXT;
        end
      end
      ST_XFER: if (xferDone) begin
        stb.recPass = xferPass;
        stb.recFail = !xferPass;
        stateNxt    = ST_NEXT;
      end
      ST_NEXT: begin
        if (lastTap) begin
          stateNxt = ST_EVAL;
        end else begin
          stb.incTap = 1'b1;
          stateNxt   = ST_APPLY;
        end
      end
      ST_EVAL: begin
        if (anyPass) begin
          stb.loadFinal = 1'b1;
          stateNxt      = ST_FINAL;
        end else begin
          errSet   = 1'b1;
          stateNxt = ST_FIN;
        end
      end
      ST_FINAL: begin
        stb.toRun = 1'b1;
        if (tapApplyAck) begin
          stateNxt = ST_FIN;
        end else if (timeout) begin
          errSet   = 1'b1;
          stateNxt = ST_FIN;
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      error <= 1'b0;
    end else begin
      state <= stateNxt;
      if (errSet)      error <= 1'b1;
      else if (errClr) error <= 1'b0;
    end
  end

  assign tapApplyReq = (state == ST_APPLY) || (state == ST_FINAL);
  assign xferReq     = (state == ST_XFER);
  assign done        = (state == ST_FIN);

  // R9: error holds until an accepted start
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    error && !(state == ST_IDLE && start) |=> error);

  // R8: wrong mode start reports error on the next cycle with done
  p_mode_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && start && (modeSel != HS200_CODE) |=> error && done);

  // R3: a timed-out apply never leads to a transfer
  p_timeout_no_xfer_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_APPLY) && timeout && !tapApplyAck |=> !xferReq);

endmodule

// File: rtl/tap_sweep_tuner.sv
module tap_sweep_tuner
  import tuner_pkg::*;
#(
  parameter int             TAP_W       = 6,
  parameter int             NUM_TAPS    = 40,
  parameter int             ACK_TIMEOUT = 16,
  parameter int             MODE_W      = 3,
  parameter logic [MODE_W-1:0] HS200_CODE = MODE_W'(5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeSel,
  output logic              done,
  output logic              error,
  output logic [TAP_W-1:0]  tapVal,
  output logic              tapApplyReq,
  input  logic              tapApplyAck,
  output logic              xferReq,
  input  logic              xferDone,
  input  logic              xferPass
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  dpStrobe_t stb;
  logic      lastTap, anyPass, timeout;

  tuner_ctrl #(
    .MODE_W     (MODE_W),
    .HS200_CODE (HS200_CODE)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .modeSel     (modeSel),
    .tapApplyAck (tapApplyAck),
    .xferDone    (xferDone),
    .xferPass    (xferPass),
    .lastTap     (lastTap),
    .anyPass     (anyPass),
    .timeout     (timeout),
    .stb         (stb),
    .tapApplyReq (tapApplyReq),
    .xferReq     (xferReq),
    .done        (done),
    .error       (error)
  );

  tuner_dpath #(
    .TAP_W       (TAP_W),
    .NUM_TAPS    (NUM_TAPS),
    .ACK_TIMEOUT (ACK_TIMEOUT)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .tapVal  (tapVal),
    .lastTap (lastTap),
    .anyPass (anyPass),
    .timeout (timeout)
  );

  // R1: never offer a tap outside the safe range
  p_tap_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    tapApplyReq |-> tapVal <= LAST_TAP);

  // R2: tap is stable while its request is pending
  p_tap_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    tapApplyReq && !tapApplyAck |=> !tapApplyReq || $stable(tapVal));

  // R2: a transfer starts only right after an acknowledged apply
  p_xfer_after_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferReq) |-> $past(tapApplyAck) && $past(tapApplyReq));

  // R2: apply and transfer requests never overlap
  p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(tapApplyReq && xferReq));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/test_tap_sweep_tuner.sv
module test_tap_sweep_tuner;

  localparam int NT      = 40;
  localparam int ACK_LAT = 2;
  localparam int XF_LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] modeSel = 3'd5;
  logic done, error, tapApplyReq, xferReq;
  logic [5:0] tapVal;
  logic tapApplyAck = 1'b0, xferDone = 1'b0, xferPass = 1'b0;

  logic [NT-1:0] passMask = '0;
  logic [NT-1:0] noAckMask = '0;

  int checks = 0, errors = 0, cyc = 0;
  int logTap [0:127];
  int logN = 0, doneCnt = 0, protoBad = 0;
  int ackCnt = 0, xfCnt = 0;
  logic prevReq = 1'b0;
  logic [5:0] prevTap = '0;

  tap_sweep_tuner i_tap_sweep_tuner (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .done(done), .error(error), .tapVal(tapVal),
    .tapApplyReq(tapApplyReq), .tapApplyAck(tapApplyAck),
    .xferReq(xferReq), .xferDone(xferDone), .xferPass(xferPass)
  );

  always #10 clk = ~clk;

  // Delay-line and transfer models, driven away from the active edge
  always @(negedge clk) begin
    if (!tapApplyReq) begin
      ackCnt = 0; tapApplyAck = 1'b0;
    end else if ((tapVal < NT) ? noAckMask[tapVal] : 1'b1) begin
      tapApplyAck = 1'b0;
    end else if (ackCnt >= ACK_LAT) begin
      tapApplyAck = 1'b1;
    end else begin
      ackCnt++;
    end
    if (!xferReq) begin
      xfCnt = 0; xferDone = 1'b0; xferPass = 1'b0;
    end else if (xfCnt >= XF_LAT) begin
      xferDone = 1'b1;
      xferPass = (tapVal < NT) ? passMask[tapVal] : 1'b0;
    end else begin
      xfCnt++;
    end
  end

  // Protocol monitor
  always @(posedge clk) begin
    cyc++;
    if (rstN) begin
      if (tapApplyReq && tapApplyAck) begin
        if (logN < 128) logTap[logN] = int'(tapVal);
        logN++;
      end
      if (done) doneCnt++;
      if (prevReq && tapApplyReq && tapVal != prevTap) protoBad++;
      if (xferReq && ((tapVal < NT) ? noAckMask[tapVal] : 1'b1)) protoBad++;
      prevReq = tapApplyReq && !tapApplyAck;
      prevTap = tapVal;
    end
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCase(input string name, input logic [NT-1:0] pm,
                         input logic [NT-1:0] nm, input logic [2:0] mode);
    int cur, best, endI, expFinal, expN, waitC;
    bit expErr, seqOk, sawDone;
    int expSeq [0:127];
    cur = 0; best = 0; endI = 0; expN = 0;
    passMask = pm; noAckMask = nm;
    if (mode == 3'd5) begin
      for (int i = 0; i < NT; i++) begin
        if (!nm[i]) begin expSeq[expN] = i; expN++; end
        if (pm[i] && !nm[i]) begin
          cur++;
          if (cur > best) begin best = cur; endI = i; end
        end else cur = 0;
      end
    end
    expErr   = (mode != 3'd5) || (best == 0);
    expFinal = endI - best / 2;
    if (!expErr) begin expSeq[expN] = expFinal; expN++; end
    @(negedge clk);
    logN = 0; doneCnt = 0; protoBad = 0;
    modeSel = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = 1'b0;
    for (waitC = 0; waitC < 5000 && !sawDone; waitC++) begin
      if (done) sawDone = 1'b1;
      else @(negedge clk);
    end
    chk(sawDone, "R9", {name, " done seen"}, int'(sawDone), 1);
    chk(error == expErr, expErr ? "R7/R8" : "R9", {name, " error flag"}, int'(error), int'(expErr));
    if (!expErr)
      chk(int'(tapVal) == expFinal, "R5", {name, " final tap"}, int'(tapVal), expFinal);
    seqOk = (logN == expN);
    for (int k = 0; k < expN && k < 128; k++) if (seqOk && logTap[k] != expSeq[k]) seqOk = 1'b0;
    chk(seqOk, "R1", {name, " applied tap sequence, count"}, logN, expN);
    chk(protoBad == 0, "R2", {name, " protocol violations"}, protoBad, 0);
    @(negedge clk);
    chk(!done && doneCnt == 1, "R9", {name, " done pulses"}, doneCnt, 1);
    chk(error == expErr, "R9", {name, " error held"}, int'(error), int'(expErr));
  endtask

  function automatic logic [NT-1:0] win(input int lo, input int hi);
    logic [NT-1:0] m = '0;
    for (int i = lo; i <= hi && i < NT; i++) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !error && !tapApplyReq && !xferReq, "R10", "outputs in reset",
        int'({done, error, tapApplyReq, xferReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !error && !tapApplyReq && !xferReq, "R10", "outputs after reset",
        int'({done, error, tapApplyReq, xferReq}), 0);

    runCase("R8 wrong mode", '1, '0, 3'd2);
    runCase("R4 all pass", '1, '0, 3'd5);
    runCase("R7 none pass", '0, '0, 3'd5);
    runCase("R9 recover all pass", '1, '0, 3'd5);
    runCase("R5 equal windows", win(3, 6) | win(20, 23), '0, 3'd5);
    runCase("R5 longer later", win(2, 4) | win(10, 17), '0, 3'd5);
    runCase("R5 odd window", win(5, 9), '0, 3'd5);
    runCase("R3 ack timeouts", '1, (NT'(1) << 10) | (NT'(1) << 25), 3'd5);
    runCase("R3 all timeouts", '1, '1, 3'd5);
    runCase("R8 mode zero", win(0, 5), '0, 3'd0);

    // Near-exhaustive: single passing tap and three-wide windows at each position
    for (int k = 0; k < NT; k++) runCase("R5 single tap", NT'(1) << k, '0, 3'd5);
    for (int k = 0; k < NT - 2; k++) runCase("R5 window3", win(k, k + 2), '0, 3'd5);
    // Even windows ending at the last tap (R6 final apply)
    for (int w = 1; w <= 8; w++) runCase("R6 tail window", win(NT - 2 * w, NT - 1), '0, 3'd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule